// File: doc/BRIEF.md
# Execution-Phase Byte Transfer Handshake

This block carries data bytes between the disk-side byte stream and the host bus while a controller command is in its execution phase. A pulse on `exec_start` opens the phase and captures the transfer direction and the handshake mode. In interrupt mode every byte raises `int_o` and the request-for-master status bit `rqm_o` together. A host can either service the interrupt or poll the status bit. In DMA mode the per-byte interrupt stays quiet and `drq_o` asks an external DMA engine for each byte instead.

The phase closes on a rising terminal count or on a `last_sector` pulse from the sector logic. Closing the phase raises `int_o` to announce the result phase. The first host read after that clears it. Host strobes, DACK and TC are synchronised through two flops and edge-detected in the 8 MHz clock domain. At that rate one byte takes roughly 100 clocks in MFM and 200 in FM. The block therefore has plenty of cycles for each handshake. A disk byte that arrives while the previous one is still untaken sets a sticky overrun flag.

Top module: `xfer_handshake`

## Requirements
- R1: After reset, `int_o`, `drq_o`, `rqm_o`, `exec_o` and `overrun_o` are all 0.
- R2: In interrupt mode during a read (`dir_write`=0 at start), a `disk_rdy` pulse loads `disk_din` into `host_dout` and raises both `int_o` and `rqm_o`. While the phase runs, `int_o` equals `rqm_o`.
- R3: In interrupt-mode reads, a falling `host_rd_n` clears `int_o` and `rqm_o`. While `host_rd_n` is low, `host_oe` is 1 and `host_dout` carries the byte.
- R4: In interrupt-mode writes (`dir_write`=1 at start), a `disk_rdy` pulse raises `int_o`. A falling `host_wr_n` clears it and places `host_din` on `disk_dout`. A `host_rd_n` strobe during a write leaves `int_o` at 1.
- R5: In DMA mode (`dma_mode`=1 at start), `int_o` stays 0 while `exec_o` is 1. Each `disk_rdy` pulse raises `drq_o` and `rqm_o`. `drq_o` is never 1 outside a DMA execution phase.
- R6: `drq_o` returns to 0 once `host_dack_n` is low, before any data strobe occurs.
- R7: In DMA mode, a data strobe while `host_dack_n` is high moves no byte, so `rqm_o` stays 1.
- R8: A rising `host_tc` during the phase clears `exec_o`, `drq_o` and `rqm_o` and sets `int_o`.
- R9: A `last_sector` pulse during the phase ends it in the same way as terminal count: `exec_o` becomes 0 and `int_o` becomes 1.
- R10: The end-of-phase interrupt is cleared by the next falling `host_rd_n` or by `exec_start`.
- R11: A `disk_rdy` pulse while a byte is still pending sets `overrun_o`. The flag stays set until the next `exec_start`.
- R12: `dma_mode` and `dir_write` are sampled only at `exec_start`. Changes during the phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_start | input | 1 | One-cycle pulse that opens the execution phase |
| dir_write | input | 1 | 1 = host-to-disk command, sampled at start |
| dma_mode | input | 1 | 1 = DMA handshake, sampled at start |
| disk_rdy | input | 1 | One-cycle pulse: byte available (read) or byte needed (write) |
| disk_din | input | DW | Byte from the disk side |
| last_sector | input | 1 | One-cycle pulse: final sector done |
| disk_dout | output | DW | Byte for the disk side |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| host_tc | input | 1 | Terminal count, active high, asynchronous |
| host_din | input | DW | Host data bus in |
| host_dout | output | DW | Host data bus out |
| host_oe | output | 1 | Host data bus output enable |
| int_o | output | 1 | Interrupt request |
| drq_o | output | 1 | DMA request |
| rqm_o | output | 1 | Request-for-master status bit |
| exec_o | output | 1 | Execution phase active |
| overrun_o | output | 1 | Sticky byte-overrun flag |

## Verification
On every cycle the assertions check the mode invariants. No per-byte interrupt is raised in DMA mode, and DRQ never appears outside DMA execution. Interrupt and status bit agree in interrupt mode. The latched mode holds steady through the phase, overrun stays sticky, and every close of the phase raises the interrupt. Only the bench scenarios can show the data movement itself. That covers the byte reaching `host_dout` or `disk_dout`, strobes in the wrong direction or without DACK being ignored, and the end interrupt being cleared by a later host read.

// File: rtl/xfer_handshake.sv
module xfer_handshake #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_start,
  input  logic          dir_write,
  input  logic          dma_mode,
  input  logic          disk_rdy,
  input  logic [DW-1:0] disk_din,
  input  logic          last_sector,
  output logic [DW-1:0] disk_dout,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_dack_n,
  input  logic          host_tc,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_oe,
  output logic          int_o,
  output logic          drq_o,
  output logic          rqm_o,
  output logic          exec_o,
  output logic          overrun_o
);

  logic [2:0] rd_q, wr_q, tc_q;
  logic [1:0] dack_q;
  logic exec_q, dma_q, wdir_q, pend_q, drq_q, endi_q, ovr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '1;
      wr_q   <= '1;
      tc_q   <= '0;
      dack_q <= '1;
    end else begin
      rd_q   <= {rd_q[1:0], host_rd_n};
      wr_q   <= {wr_q[1:0], host_wr_n};
      tc_q   <= {tc_q[1:0], host_tc};
      dack_q <= {dack_q[0], host_dack_n};
    end
  end

  wire rd_fall = rd_q[2] & ~rd_q[1];
  wire wr_fall = wr_q[2] & ~wr_q[1];
  wire tc_rise = ~tc_q[2] & tc_q[1];
  wire dack_lo = ~dack_q[1];
  wire strobe  = wdir_q ? wr_fall : rd_fall;
  wire serve   = exec_q & pend_q & strobe & (~dma_q | dack_lo);
  wire fin     = exec_q & (tc_rise | last_sector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      dma_q  <= 1'b0;
      wdir_q <= 1'b0;
      pend_q <= 1'b0;
      drq_q  <= 1'b0;
      endi_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else if (exec_start && !exec_q) begin
      exec_q <= 1'b1;
      dma_q  <= dma_mode;
      wdir_q <= dir_write;
      pend_q <= 1'b0;
      drq_q  <= 1'b0;
      endi_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (fin) begin
      exec_q <= 1'b0;
      pend_q <= 1'b0;
      drq_q  <= 1'b0;
      endi_q <= 1'b1;
    end else if (exec_q) begin
      if (dack_lo) drq_q <= 1'b0;
      if (serve) begin
        pend_q <= 1'b0;
        if (wdir_q) data_q <= host_din;
      end
      if (disk_rdy) begin
        if (pend_q && !serve) ovr_q <= 1'b1;
        pend_q <= 1'b1;
        if (!wdir_q) data_q <= disk_din;
        if (dma_q) drq_q <= 1'b1;
      end
    end else if (rd_fall) begin
      endi_q <= 1'b0;
    end
  end

  assign disk_dout = data_q;
  assign host_dout = data_q;
  assign host_oe   = exec_q & ~wdir_q & ~host_rd_n & (~dma_q | ~host_dack_n);
  assign int_o     = endi_q | (exec_q & ~dma_q & pend_q);
  assign drq_o     = drq_q;
  assign rqm_o     = exec_q & pend_q;
  assign exec_o    = exec_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/xfer_handshake_chk.sv
module xfer_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic exec_start,
  input logic int_o,
  input logic drq_o,
  input logic rqm_o,
  input logic exec_o,
  input logic overrun_o,
  input logic dma_q
);
  AST_NO_BYTE_INT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && dma_q) |-> !int_o); // R5
  AST_DRQ_ONLY_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    drq_o |-> (exec_o && dma_q)); // R5
  AST_INT_TRACKS_RQM: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !dma_q) |-> (int_o == rqm_o)); // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !exec_start) |=> overrun_o); // R11
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && $past(exec_o)) |-> $stable(dma_q)); // R12
  AST_END_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exec_o) |-> int_o); // R8
endmodule

bind xfer_handshake xfer_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .int_o(int_o),
  .drq_o(drq_o), .rqm_o(rqm_o), .exec_o(exec_o), .overrun_o(overrun_o),
  .dma_q(dma_q)
);

// File: tb/xfer_handshake_tb.sv
module xfer_handshake_tb;
  localparam int CLK_NS = 125;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic exec_start = 0, dir_write = 0, dma_mode = 0, disk_rdy = 0, last_sector = 0;
  logic host_rd_n = 1, host_wr_n = 1, host_dack_n = 1, host_tc = 0;
  logic [DW-1:0] disk_din = 0, host_din = 0, disk_dout, host_dout;
  logic host_oe, int_o, drq_o, rqm_o, exec_o, overrun_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  xfer_handshake #(.DW(DW)) u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(bit dma, bit wdir);
    @(negedge clk); dma_mode = dma; dir_write = wdir; exec_start = 1;
    @(negedge clk); exec_start = 0;
  endtask

  task automatic pulse_rdy(logic [DW-1:0] b);
    @(negedge clk); disk_din = b; disk_rdy = 1;
    @(negedge clk); disk_rdy = 0;
  endtask

  task automatic pulse_last();
    @(negedge clk); last_sector = 1;
    @(negedge clk); last_sector = 0;
  endtask

  task automatic rd_strobe(bit chk_bus, logic [DW-1:0] b);
    @(negedge clk); host_rd_n = 0;
    wait_n(2);
    if (chk_bus) begin
      chk("R3 host_oe", host_oe, 1);
      chk("R3 host_dout", host_dout, b);
    end
    wait_n(3); host_rd_n = 1; wait_n(4);
  endtask

  task automatic wr_strobe(logic [DW-1:0] b);
    @(negedge clk); host_din = b; host_wr_n = 0;
    wait_n(5); host_wr_n = 1; wait_n(4);
  endtask

  // {dma, wdir, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h81}, {1'b0, 1'b1, 8'h5A}};

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R1 int", int_o, 0); chk("R1 drq", drq_o, 0); chk("R1 rqm", rqm_o, 0);
    chk("R1 exec", exec_o, 0); chk("R1 ovr", overrun_o, 0);
    @(negedge clk); rst_n = 1; wait_n(2);

    for (int i = 0; i < 6; i++) begin
      bit dma = VEC[i][9], wdir = VEC[i][8];
      logic [DW-1:0] b = VEC[i][7:0];
      start(dma, wdir);
      pulse_rdy(b); wait_n(1);
      chk("R2 rqm set", rqm_o, 1);
      if (!dma) begin
        chk("R2 int set", int_o, 1); chk("R5 no drq", drq_o, 0);
      end else begin
        chk("R5 no int", int_o, 0); chk("R5 drq set", drq_o, 1);
        @(negedge clk); host_dack_n = 0; wait_n(4);
        chk("R6 drq cleared", drq_o, 0);
      end
      if (wdir) begin
        wr_strobe(b);
        chk("R4 disk_dout", disk_dout, b);
      end else rd_strobe(1, b);
      chk("R3 rqm clear", rqm_o, 0); chk("R3 int clear", int_o, 0);
      host_dack_n = 1;
      pulse_last(); wait_n(1);
      chk("R9 exec end", exec_o, 0); chk("R9 end int", int_o, 1);
      rd_strobe(0, 0);
      chk("R10 end int cleared", int_o, 0);
    end

    // R7: DMA strobe without DACK ignored
    start(1, 0); pulse_rdy(8'h11); rd_strobe(0, 0);
    chk("R7 rqm kept", rqm_o, 1); chk("R7 drq kept", drq_o, 1);
    // R8: terminal count ends phase
    @(negedge clk); host_tc = 1; wait_n(5); host_tc = 0;
    chk("R8 exec", exec_o, 0); chk("R8 int", int_o, 1);
    chk("R8 drq", drq_o, 0); chk("R8 rqm", rqm_o, 0);
    // R10: exec_start clears end interrupt; R4: RD ignored during write
    start(0, 1);
    chk("R10 start clears int", int_o, 0);
    pulse_rdy(8'h00); rd_strobe(0, 0);
    chk("R4 rd ignored", int_o, 1);
    wr_strobe(8'h77); chk("R4 wr clears", int_o, 0);
    pulse_last(); rd_strobe(0, 0);
    // R11: overrun
    start(0, 0); pulse_rdy(8'h01); pulse_rdy(8'h02); wait_n(1);
    chk("R11 ovr set", overrun_o, 1);
    chk("R11 newest byte", host_dout, 8'h02);
    rd_strobe(0, 0);
    chk("R11 ovr sticky", overrun_o, 1);
    pulse_last(); rd_strobe(0, 0);
    start(0, 0); chk("R11 ovr cleared", overrun_o, 0);
    pulse_last(); rd_strobe(0, 0);
    // R12: mode latched at start
    start(0, 0); @(negedge clk); dma_mode = 1; dir_write = 1;
    pulse_rdy(8'h42); wait_n(1);
    chk("R12 int mode kept", int_o, 1); chk("R12 no drq", drq_o, 0);
    rd_strobe(1, 8'h42);
    chk("R12 read dir kept", rqm_o, 0);
    pulse_last(); rd_strobe(0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule